// File: doc/BRIEF.md
# March-Sequence Memory Self-Test Engine

This block tests a single-port synchronous RAM with no outside help once it has been started. A pulse on `start_i` runs a fixed six-pass march over the whole array. Each pass sweeps the addresses up or down and, at each address, reads the word and checks it, writes the opposite value, or does both. The logical address from the sweep counter is XORed with a key before it goes to the RAM. Write data and expected read data come from one of four background patterns, so a "0" in the march is the chosen background word and a "1" is its complement.

Every returned read word is compared against the value it should hold. It is also folded into a signature register. At the end the block holds `done_o`, reports pass or fail, gives the first failing physical address, and shows the final signature. In diagnostic mode the run always finishes and each miscompare produces a one-cycle report. In go/no-go mode the run stops at the first miscompare.

Top module: `mbist_march`

## Requirements
- R1: One run issues exactly 10 RAM operations per address, one per cycle, across six passes in this order. P0 writes 0. P1 reads 0 then writes 1. P2 reads 1 then writes 0. P3 reads 0 then writes 1. P4 reads 1 then writes 0. P5 reads 0. Both operations of a pass finish at one address before the next address starts. `ram_en_o` is high for every operation, and `ram_we_o` is high only for writes.
- R2: P0, P1 and P2 sweep logical addresses from 0 up to 2^AW-1. P3, P4 and P5 sweep from 2^AW-1 down to 0.
- R3: `ram_addr_o` equals the logical address XOR the key latched at start. Every physical location is therefore visited once per sweep.
- R4: Background select `bg_sel_i` sets the word written or expected for "0". The codes are: 0 gives all zeros. 1 gives all ones. 2 gives a checkerboard whose bit i is 1 for odd i, inverted when bit 0 of the physical address is 1. 3 gives the complement of code 2. A "1" is the bitwise complement of the "0" word.
- R5: The RAM has one cycle of read latency. Each read is compared with `ram_rdata_i` in the cycle after the read was issued. With a fault-free RAM, `done_o` rises 10·2^AW+1 clock edges after the edge that accepted start, with `pass_o`=1 and `fail_o`=0.
- R6: The signature loads SEED (default 8'hFF) when start is accepted. Each returned read word d updates it as sig = (sig<<1) ^ (sig[DW-1] ? POLY : 0) ^ d, with POLY defaulting to 8'h1D. The signature is held after done.
- R7: In diagnostic mode (`diag_i`=1 at start), each miscompare gives a one-cycle `err_valid_o` pulse. The pulse carries the physical address and expected XOR actual on `err_xor_o`, and the run continues to full length.
- R8: In go/no-go mode, the first miscompare sets `fail_o`. `done_o` is raised at the next edge after the compare, which is 2 edges after the failing read was issued. No `err_valid_o` pulse occurs in this mode.
- R9: `start_i` is accepted only when not busy. While busy it is ignored, and changes to the background, key or mode inputs during a run have no effect.
- R10: `done_o` stays high until the next accepted start. `fail_o` stays set until then. `pass_o` is `done_o` and not `fail_o`. `first_fail_addr_o` holds the physical address of the earliest miscompare.
- R11: After reset the block is idle. `busy_o`, `done_o`, `pass_o`, `fail_o`, `err_valid_o` and `ram_en_o` are 0, and the signature equals SEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when not busy |
| bg_sel_i | input | 2 | Background pattern code |
| scr_key_i | input | AW | Address scramble key |
| diag_i | input | 1 | 1 = diagnostic mode, 0 = go/no-go |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AW | Physical RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, one cycle after the read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held |
| pass_o | output | 1 | Finished without miscompare |
| fail_o | output | 1 | A miscompare occurred, held |
| first_fail_addr_o | output | AW | Physical address of first miscompare |
| err_valid_o | output | 1 | Miscompare report strobe (diagnostic mode) |
| err_addr_o | output | AW | Physical address of reported miscompare |
| err_xor_o | output | DW | Expected XOR actual of reported miscompare |
| signature_o | output | DW | Signature register |

## Verification
The hardest behaviour to reach from the ports is a miscompare at a chosen point in the march, with a known bit pattern, under a scrambled address order and a non-solid background. The bench RAM model can force one bit of one physical word to a fixed value on every read. The bench then walks the march description itself to predict which reads fail, the abort cycle in go/no-go mode, and the exact faulty signature. A start pulse is also issued mid-run, together with changed mode inputs, to show that the run in progress is unaffected.

// File: rtl/mbist_march.sv
module mbist_march #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] POLY = 'h1D,
  parameter logic [DW-1:0] SEED = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    bg_sel_i,
  input  logic [AW-1:0] scr_key_i,
  input  logic          diag_i,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic [AW-1:0] first_fail_addr_o,
  output logic          err_valid_o,
  output logic [AW-1:0] err_addr_o,
  output logic [DW-1:0] err_xor_o,
  output logic [DW-1:0] signature_o
);

  localparam logic [AW-1:0] ADDR_TOP = '1;
  localparam logic [2:0]    LAST_PASS = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} state_t;

  state_t        state_q;
  logic [2:0]    pass_q;
  logic          op_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    bg_q;
  logic [AW-1:0] key_q;
  logic          diag_q;
  logic          cmp_en_q;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] cmp_addr_q;
  logic [DW-1:0] sig_q;
  logic          fail_q;
  logic [AW-1:0] ffa_q;
  logic          errv_q;
  logic [AW-1:0] erra_q;
  logic [DW-1:0] errx_q;

  logic [DW-1:0] chk_base;
  for (genvar i = 0; i < DW; i++) begin : g_chk
    assign chk_base[i] = (i % 2) == 1;
  end

  wire two_ops  = (pass_q != 3'd0) && (pass_q != LAST_PASS);
  wire desc     = pass_q >= 3'd3;
  wire is_read  = (pass_q == LAST_PASS) || (two_ops && !op_q);
  wire read_one = (pass_q == 3'd2) || (pass_q == 3'd4);
  wire op_val   = two_ops && (op_q ? !read_one : read_one);
  wire issue    = state_q == S_RUN;
  wire start_ok = start_i && (state_q == S_IDLE || state_q == S_DONE);
  wire addr_end = desc ? (addr_q == '0) : (addr_q == ADDR_TOP);
  wire addr_last_op = !two_ops || op_q;

  wire [AW-1:0] phys = addr_q ^ key_q;

  logic [DW-1:0] bg_word;
  always_comb begin
    case (bg_q)
      2'd0:    bg_word = '0;
      2'd1:    bg_word = '1;
      2'd2:    bg_word = chk_base ^ {DW{phys[0]}};
      default: bg_word = ~chk_base ^ {DW{phys[0]}};
    endcase
  end

  wire [DW-1:0] data_word = op_val ? ~bg_word : bg_word;
  wire          mis       = cmp_en_q && (ram_rdata_i != exp_q);
  wire          abort     = mis && !diag_q;
  wire [DW-1:0] misr_next = {sig_q[DW-2:0], 1'b0} ^ (sig_q[DW-1] ? POLY : '0) ^ ram_rdata_i;

  assign ram_en_o          = issue;
  assign ram_we_o          = issue && !is_read;
  assign ram_addr_o        = phys;
  assign ram_wdata_o       = data_word;
  assign busy_o            = (state_q == S_RUN) || (state_q == S_DRAIN);
  assign done_o            = state_q == S_DONE;
  assign pass_o            = done_o && !fail_q;
  assign fail_o            = fail_q;
  assign first_fail_addr_o = ffa_q;
  assign err_valid_o       = errv_q;
  assign err_addr_o        = erra_q;
  assign err_xor_o         = errx_q;
  assign signature_o       = sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pass_q  <= '0;
      op_q    <= 1'b0;
      addr_q  <= '0;
      bg_q    <= '0;
      key_q   <= '0;
      diag_q  <= 1'b0;
    end else if (start_ok) begin
      state_q <= S_RUN;
      pass_q  <= '0;
      op_q    <= 1'b0;
      addr_q  <= '0;
      bg_q    <= bg_sel_i;
      key_q   <= scr_key_i;
      diag_q  <= diag_i;
    end else if (abort) begin
      state_q <= S_DONE;
    end else if (state_q == S_DRAIN) begin
      state_q <= S_DONE;
    end else if (issue) begin
      if (!addr_last_op) begin
        op_q <= 1'b1;
      end else begin
        op_q <= 1'b0;
        if (!addr_end) begin
          addr_q <= desc ? addr_q - 1'b1 : addr_q + 1'b1;
        end else if (pass_q == LAST_PASS) begin
          state_q <= S_DRAIN;
        end else begin
          pass_q <= pass_q + 3'd1;
          addr_q <= (pass_q >= 3'd2) ? ADDR_TOP : '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_en_q   <= 1'b0;
      exp_q      <= '0;
      cmp_addr_q <= '0;
    end else begin
      cmp_en_q   <= issue && is_read && !abort;
      exp_q      <= data_word;
      cmp_addr_q <= phys;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q  <= SEED;
      fail_q <= 1'b0;
      ffa_q  <= '0;
      errv_q <= 1'b0;
      erra_q <= '0;
      errx_q <= '0;
    end else if (start_ok) begin
      sig_q  <= SEED;
      fail_q <= 1'b0;
      ffa_q  <= '0;
      errv_q <= 1'b0;
    end else begin
      errv_q <= mis && diag_q;
      if (cmp_en_q) sig_q <= misr_next;
      if (mis) begin
        fail_q <= 1'b1;
        erra_q <= cmp_addr_q;
        errx_q <= ram_rdata_i ^ exp_q;
        if (!fail_q) ffa_q <= cmp_addr_q;
      end
    end
  end

endmodule

module mbist_march_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] SEED = '1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ram_en_o,
  input logic          ram_we_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          err_valid_o,
  input logic          diag_q,
  input logic [DW-1:0] signature_o
);

  p_we_needs_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_en_o);

  p_quiet_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ram_en_o);

  p_seed_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (signature_o == SEED));

  p_err_diag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> (diag_q && fail_o));

  p_gng_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fail_o) && !diag_q) |-> (done_o && !busy_o));

  p_done_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_fail_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !(start_i && !busy_o)) |=> fail_o);

  p_busy_done_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

endmodule

bind mbist_march mbist_march_chk #(.AW(AW), .DW(DW), .SEED(SEED)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .start_i(start_i),
  .ram_en_o(ram_en_o),
  .ram_we_o(ram_we_o),
  .busy_o(busy_o),
  .done_o(done_o),
  .fail_o(fail_o),
  .err_valid_o(err_valid_o),
  .diag_q(diag_q),
  .signature_o(signature_o)
);

// File: tb/mbist_march_tb_top.sv
module mbist_march_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int N = 1 << AW;
  localparam int TOT = 10 * N;
  localparam logic [DW-1:0] POLY = 8'h1D;
  localparam logic [DW-1:0] SEED = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 0;
  logic [1:0]    bg_sel = 0;
  logic [AW-1:0] key = 0;
  logic          diag = 0;
  logic          ram_en, ram_we, busy, done, pass_w, fail_w, errv;
  logic [AW-1:0] ram_addr, ffa, erra;
  logic [DW-1:0] ram_wdata, ram_rdata, errx, sig;

  mbist_march #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bg_sel_i(bg_sel),
    .scr_key_i(key), .diag_i(diag), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .busy_o(busy), .done_o(done), .pass_o(pass_w), .fail_o(fail_w),
    .first_fail_addr_o(ffa), .err_valid_o(errv), .err_addr_o(erra),
    .err_xor_o(errx), .signature_o(sig)
  );

  // RAM model with an optional single stuck bit on read
  logic [DW-1:0] mem [N];
  logic          f_on = 0;
  logic [AW-1:0] f_addr = 0;
  int            f_bit = 0;
  logic          f_val = 0;

  function automatic logic [DW-1:0] faulty(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    if (f_on && a == f_addr) r[f_bit] = f_val;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= faulty(ram_addr, mem[ram_addr]);
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // march model built from the requirements
  function automatic void exp_op(input int k, input logic [1:0] bg, input logic [AW-1:0] kk,
                                 output logic we, output logic [AW-1:0] a,
                                 output logic [DW-1:0] d);
    int rem = k;
    we = 0; a = 0; d = 0;
    for (int p = 0; p < 6; p++) begin
      int n = (p == 0 || p == 5) ? 1 : 2;
      if (rem < n * N) begin
        int pos = rem / n;
        int op = rem % n;
        logic [AW-1:0] la = (p >= 3) ? AW'(N - 1 - pos) : AW'(pos);
        logic one;
        logic [DW-1:0] chkw, bgw;
        a = la ^ kk;
        if (p == 0) begin we = 1; one = 0; end
        else if (p == 5) begin we = 0; one = 0; end
        else begin
          we = (op == 1);
          one = (p == 2 || p == 4) ^ (op == 1);
        end
        for (int i = 0; i < DW; i++) chkw[i] = (i % 2) == 1;
        case (bg)
          2'd0: bgw = '0;
          2'd1: bgw = '1;
          2'd2: bgw = chkw ^ {DW{a[0]}};
          default: bgw = ~chkw ^ {DW{a[0]}};
        endcase
        d = one ? ~bgw : bgw;
        return;
      end
      rem -= n * N;
    end
  endfunction

  function automatic logic [DW-1:0] misr(input logic [DW-1:0] s, input logic [DW-1:0] d);
    return {s[DW-2:0], 1'b0} ^ (s[DW-1] ? POLY : '0) ^ d;
  endfunction

  task automatic predict(input logic [1:0] bg, input logic [AW-1:0] kk,
                         output logic [DW-1:0] s, output int nfail, output int firstk);
    logic we; logic [AW-1:0] a; logic [DW-1:0] d, r;
    s = SEED; nfail = 0; firstk = -1;
    for (int k = 0; k < TOT; k++) begin
      exp_op(k, bg, kk, we, a, d);
      if (!we) begin
        r = faulty(a, d);
        s = misr(s, r);
        if (r != d) begin
          nfail++;
          if (firstk < 0) firstk = k;
        end
      end
    end
  endtask

  // stream monitors
  bit mon_on = 0;
  logic [1:0] m_bg; logic [AW-1:0] m_key;
  int opidx, opbad, errcnt, errbad;
  always @(negedge clk) begin
    if (mon_on) begin
      if (ram_en) begin
        logic we; logic [AW-1:0] a; logic [DW-1:0] d;
        exp_op(opidx, m_bg, m_key, we, a, d);
        if (opidx >= TOT || ram_we != we || ram_addr != a || (we && ram_wdata != d)) begin
          if (opbad == 0)
            $display("  op %0d mismatch: we=%0b addr=%0h data=%0h / we=%0b addr=%0h data=%0h",
                     opidx, ram_we, ram_addr, ram_wdata, we, a, d);
          opbad++;
        end
        opidx++;
      end
      if (errv) begin
        logic [DW-1:0] one = 1;
        errcnt++;
        if (erra != f_addr || errx != (one << f_bit)) errbad++;
      end
    end
  end

  task automatic run_march(input logic [1:0] bg, input logic [AW-1:0] kk, input logic dg,
                           input int poke_at, output int cycles);
    m_bg = bg; m_key = kk; opidx = 0; opbad = 0; errcnt = 0; errbad = 0;
    for (int i = 0; i < N; i++) mem[i] = '0;
    @(negedge clk);
    bg_sel = bg; key = kk; diag = dg; start = 1; mon_on = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    cycles = 0;
    while (!done && cycles < TOT + 20) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      start = 0;
      if (cycles == poke_at) begin
        start = 1; bg_sel = ~bg; key = ~kk; diag = ~dg;
      end
    end
    mon_on = 0;
    start = 0;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !pass_w && !fail_w && !errv && !ram_en, "R11", "idle outputs", 
        {busy, done, pass_w, fail_w, errv, ram_en}, 0);
    chk(sig == SEED, "R11", "reset signature", sig, SEED);
  endtask

  task automatic t_clean(input logic [1:0] bg, input logic [AW-1:0] kk, input string tag);
    int cyc, nf, fk; logic [DW-1:0] es;
    f_on = 0;
    predict(bg, kk, es, nf, fk);
    run_march(bg, kk, 1'b0, -1, cyc);
    chk(opbad == 0 && opidx == TOT, "R1", {tag, " op stream order, R2 sweeps, R3 scramble, R4 data"}, opbad, 0);
    chk(cyc == TOT + 1, "R5", {tag, " cycles to done"}, cyc, TOT + 1);
    chk(pass_w && !fail_w, "R5", {tag, " pass"}, {pass_w, fail_w}, 2'b10);
    chk(sig == es, "R6", {tag, " signature"}, sig, es);
  endtask

  task automatic t_diag(input logic [1:0] bg, input logic [AW-1:0] kk,
                        input logic [AW-1:0] fa, input int fb, input logic fv);
    int cyc, nf, fk; logic [DW-1:0] es;
    f_on = 1; f_addr = fa; f_bit = fb; f_val = fv;
    predict(bg, kk, es, nf, fk);
    run_march(bg, kk, 1'b1, -1, cyc);
    chk(cyc == TOT + 1, "R7", "diag runs full length", cyc, TOT + 1);
    chk(errcnt == nf && nf > 0, "R7", "diag error pulse count", errcnt, nf);
    chk(errbad == 0, "R7", "diag error address/xor", errbad, 0);
    chk(fail_w && !pass_w && ffa == fa, "R10", "first fail address", ffa, fa);
    chk(sig == es, "R6", "faulty signature", sig, es);
    f_on = 0;
  endtask

  task automatic t_gng(input logic [1:0] bg, input logic [AW-1:0] kk,
                       input logic [AW-1:0] fa, input int fb, input logic fv);
    int cyc, nf, fk; logic [DW-1:0] es;
    f_on = 1; f_addr = fa; f_bit = fb; f_val = fv;
    predict(bg, kk, es, nf, fk);
    run_march(bg, kk, 1'b0, -1, cyc);
    chk(cyc == fk + 2, "R8", "abort cycle", cyc, fk + 2);
    chk(errcnt == 0, "R8", "no error pulses", errcnt, 0);
    chk(fail_w && done && ffa == fa, "R8", "fail and address", ffa, fa);
    f_on = 0;
  endtask

  task automatic t_restart_ignored;
    int cyc, nf, fk; logic [DW-1:0] es;
    f_on = 0;
    predict(2'd2, 6'h15, es, nf, fk);
    run_march(2'd2, 6'h15, 1'b0, 100, cyc);
    chk(cyc == TOT + 1, "R9", "mid-run start ignored", cyc, TOT + 1);
    chk(opbad == 0 && sig == es, "R9", "config latched at start", sig, es);
  endtask

  task automatic t_hold;
    logic [DW-1:0] s0 = sig;
    logic f0 = fail_w;
    repeat (20) @(negedge clk);
    chk(done && sig == s0 && fail_w == f0, "R10", "done/signature/fail held", {done, sig}, {1'b1, s0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean(2'd0, 6'h00, "solid0");
    t_clean(2'd1, 6'h2B, "solid1");
    t_clean(2'd2, 6'h11, "checker");
    t_clean(2'd3, 6'h3F, "inv-checker");
    t_diag(2'd0, 6'h09, 6'h21, 3, 1'b0);
    t_hold();
    t_diag(2'd2, 6'h00, 6'h07, 0, 1'b1);
    t_gng(2'd0, 6'h05, 6'h1C, 6, 1'b1);
    t_hold();
    t_gng(2'd3, 6'h3A, 6'h00, 1, 1'b0);
    t_clean(2'd0, 6'h0F, "after-fail");
    t_restart_ignored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule